// File: doc/BRIEF.md
# CardBus Bridge Configuration Header Emulator

This block stands in for a CardBus bridge that does not exist in silicon. Configuration requests arrive on a request port carrying a root-bus flag, bus number, slot, dword index, byte enables and write data. Requests aimed at the bridge's slot on the root bus are served from a synthetic type-2 header. Identity, class and header-type fields are hard-wired. Command, bus numbers, bridge control and the eight memory and IO window registers live in flip-flops.

Once software has given the bridge a nonzero CardBus bus number, requests for slot 0 on that bus go out on a forward port as type-0 cycles addressed to device 8, function 0. Only one device can therefore sit behind the bridge. Every other request completes at once as "not found". The block gives each request one outcome, one cycle after it is accepted.

Top module: `cb_hdr_emu`

## Requirements
- R1: A request sampled with req_valid high produces, one cycle later, exactly one of rsp_valid or fwd_valid. With req_valid low, neither is produced. The header is reached only when req_root is 1 and req_slot is 0x1E. Response and forward payload fields read zero in any cycle where their valid is low.
- R2: Dword 0 and dword 16 read {16'h6348, VENDOR_ID}. Dword 2 reads 32'h0607_0000, the CardBus bridge class. Dword 3 reads 32'h0002_0000, header type 2 in bits [23:16].
- R3: Dword 1 reads {16'h0400, command}, where 16'h0400 is the status value for slow device-select timing. A write stores only bits [15:0] as the command.
- R4: Dword 6 reads {latency[31:24], subordinate bus[23:16], CardBus bus[15:8], primary bus[7:0]}, and a write stores all four fields.
- R5: A write to dword 6 that leaves a nonzero CardBus bus field sets a bus-assigned flag. A later write of zero does not clear the flag; only reset clears it.
- R6: Dword 15 reads {bridge control[31:16], 8'h01 interrupt pin, 8'hFF interrupt line}. A write stores the upper half as bridge control, with bits 8 and 9 of that half (the two memory prefetch enables) forced to 0.
- R7: Dwords 7 to 14 are full 32-bit window registers: memory base 0, memory limit 0, memory base 1, memory limit 1, IO base 0, IO limit 0, IO base 1, IO limit 1. Reads of dwords 11 and 13 return bit 0 as 1.
- R8: A header write changes only the byte lanes whose req_be bit is 1. Lane n is bits [8n+7:8n]. The other lanes keep the value the dword currently reads before the fields are updated.
- R9: When the flag is set, a request whose req_bus equals the stored CardBus bus and whose req_slot is 0 is forwarded. fwd_type is 0, fwd_dev is 8 and fwd_func is 0, and the request's write flag, dword, byte enables and data pass through unchanged. Any other slot on that bus is not found.
- R10: A not-found request returns rsp_found 0 with rsp_rdata 32'hFFFF_FFFF and changes no header state.
- R11: Dwords 4, 5 and 17 to 63 read zero and ignore writes. A header write completes with rsp_found 1 and rsp_rdata 0.
- R12: Synchronous active-high reset clears every stored field and the bus-assigned flag, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_root | input | 1 | Request targets the root bus |
| req_bus | input | 8 | Bus number |
| req_slot | input | 5 | Device slot |
| req_dword | input | 6 | Dword index within the header |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Local completion |
| rsp_found | output | 1 | 1 = served by the header, 0 = not found |
| rsp_rdata | output | 32 | Read data, 0 for writes, all ones when not found |
| fwd_valid | output | 1 | Request forwarded downstream |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_type | output | 1 | Configuration cycle type (always 0) |
| fwd_dev | output | 5 | Target device number |
| fwd_func | output | 3 | Target function number |
| fwd_dword | output | 6 | Forwarded dword index |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_wdata | output | 32 | Forwarded write data |

## Verification
Full-dword reads of every implemented and unimplemented index separate the constant fields from the stored ones and the forced bits. Single-lane writes show that merging works lane by lane rather than by whole dword. Requests that vary one routing input at a time (root flag, slot, bus number, flag state) show which term of the routing decision each output depends on. A mid-run reset followed by a repeat of an earlier forward shows the assigned flag is cleared, and a zero bus write shows the flag is sticky.

// File: rtl/cbh_pkg.sv
package cbh_pkg;

    localparam int DATA_W  = 32;
    localparam int DW_W    = 6;
    localparam int BE_W    = DATA_W / 8;
    localparam int NUM_WIN = 8;

    localparam logic [DW_W-1:0] DW_IDENT    = 6'd0;
    localparam logic [DW_W-1:0] DW_CMDSTAT  = 6'd1;
    localparam logic [DW_W-1:0] DW_CLASS    = 6'd2;
    localparam logic [DW_W-1:0] DW_HDRTYPE  = 6'd3;
    localparam logic [DW_W-1:0] DW_BUSNUM   = 6'd6;
    localparam logic [DW_W-1:0] DW_WIN_BASE = 6'd7;
    localparam logic [DW_W-1:0] DW_IRQ      = 6'd15;
    localparam logic [DW_W-1:0] DW_SUBSYS   = 6'd16;

    localparam logic [15:0] STATUS_SLOW_DEVSEL = 16'h0400;
    localparam logic [15:0] CLASS_CB_BRIDGE    = 16'h0607;
    localparam logic [7:0]  HDR_TYPE_CB        = 8'h02;
    localparam logic [15:0] BCTL_PREFETCH_MASK = 16'h0300;
    localparam logic [7:0]  IRQ_PIN_A          = 8'h01;
    localparam logic [7:0]  IRQ_LINE_NONE      = 8'hFF;
    localparam logic [DATA_W-1:0] NOT_FOUND_DATA = '1;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_HDR  = 2'd1,
        RT_FWD  = 2'd2
    } route_e;

    typedef struct packed {
        logic [7:0] latency;
        logic [7:0] sub_bus;
        logic [7:0] cb_bus;
        logic [7:0] pri_bus;
    } busnum_t;

    typedef struct packed {
        logic              wr;
        logic [DW_W-1:0]   dw;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } fwd_payload_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] upd,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] m;
        m = lane_mask(be);
        return (cur & ~m) | (upd & m);
    endfunction

    // window slots 4 and 6 are the two IO base registers
    function automatic bit win_is_io_base(input int idx);
        return (idx == 4) || (idx == 6);
    endfunction

endpackage

// File: rtl/cbh_router.sv
module cbh_router
    import cbh_pkg::*;
#(
    parameter logic [4:0] BRIDGE_SLOT = 5'h1E
) (
    input  logic       req_root,
    input  logic [7:0] req_bus,
    input  logic [4:0] req_slot,
    input  logic       bus_assigned,
    input  logic [7:0] cb_bus,
    output route_e     route
);

    logic hit_bridge;
    logic hit_behind;

    assign hit_bridge = req_root && (req_slot == BRIDGE_SLOT);
    assign hit_behind = bus_assigned && (req_bus == cb_bus) && (req_slot == 5'd0);

    always_comb begin
        if (hit_bridge) begin
            route = RT_HDR;
        end else if (hit_behind) begin
            route = RT_FWD;
        end else begin
            route = RT_NONE;
        end
    end

endmodule

// File: rtl/cbh_hdr_regs.sv
module cbh_hdr_regs
    import cbh_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h6348
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DW_W-1:0]   dw,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_assigned,
    output logic [7:0]        cb_bus
);

    logic [15:0]       cmd_q;
    logic [15:0]       bctl_q;
    busnum_t           bus_q;
    logic              assigned_q;
    logic [DATA_W-1:0] win_q  [NUM_WIN];
    logic [DATA_W-1:0] win_rd [NUM_WIN];
    logic [NUM_WIN-1:0] win_sel;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] fixed_rd;
    busnum_t           bus_new;

    assign merged  = merge_lanes(rd_data, wdata, be);
    assign bus_new = busnum_t'(merged);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            assign win_sel[gi] = (dw == DW_WIN_BASE + DW_W'(gi));

            always_ff @(posedge clk) begin
                if (rst) begin
                    win_q[gi] <= '0;
                end else if (wr_en && win_sel[gi]) begin
                    win_q[gi] <= merged;
                end
            end

            if (win_is_io_base(gi)) begin : g_io32
                assign win_rd[gi] = win_q[gi] | DATA_W'(1);
            end else begin : g_plain
                assign win_rd[gi] = win_q[gi];
            end
        end
    endgenerate

    always_comb begin
        case (dw)
            DW_IDENT,
            DW_SUBSYS:  fixed_rd = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTAT: fixed_rd = {STATUS_SLOW_DEVSEL, cmd_q};
            DW_CLASS:   fixed_rd = {CLASS_CB_BRIDGE, 16'h0000};
            DW_HDRTYPE: fixed_rd = {8'h00, HDR_TYPE_CB, 16'h0000};
            DW_BUSNUM:  fixed_rd = bus_q;
            DW_IRQ:     fixed_rd = {bctl_q, IRQ_PIN_A, IRQ_LINE_NONE};
            default:    fixed_rd = '0;
        endcase
    end

    always_comb begin
        rd_data = fixed_rd;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_sel[i]) begin
                rd_data = win_rd[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            bctl_q     <= '0;
            bus_q      <= '0;
            assigned_q <= 1'b0;
        end else if (wr_en) begin
            case (dw)
                DW_CMDSTAT: cmd_q <= merged[15:0];
                DW_BUSNUM: begin
                    bus_q <= bus_new;
                    if (bus_new.cb_bus != 8'd0) begin
                        assigned_q <= 1'b1;
                    end
                end
                DW_IRQ: bctl_q <= merged[31:16] & ~BCTL_PREFETCH_MASK;
                default: ;
            endcase
        end
    end

    assign bus_assigned = assigned_q;
    assign cb_bus       = bus_q.cb_bus;

endmodule

// File: rtl/cbh_outreg.sv
module cbh_outreg
    import cbh_pkg::*;
#(
    parameter logic [4:0] FWD_DEV  = 5'd8,
    parameter logic [2:0] FWD_FUNC = 3'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  route_e            route,
    input  logic              req_write,
    input  logic [DW_W-1:0]   req_dword,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] hdr_rdata,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic              fwd_type,
    output logic [4:0]        fwd_dev,
    output logic [2:0]        fwd_func,
    output logic [DW_W-1:0]   fwd_dword,
    output logic [BE_W-1:0]   fwd_be,
    output logic [DATA_W-1:0] fwd_wdata
);

    logic         go_hdr;
    logic         go_fwd;
    logic         go_none;
    fwd_payload_t fwd_q;
    fwd_payload_t fwd_d;
    logic [DATA_W-1:0] rsp_d;

    assign go_hdr  = req_valid && (route == RT_HDR);
    assign go_fwd  = req_valid && (route == RT_FWD);
    assign go_none = req_valid && (route == RT_NONE);

    always_comb begin
        fwd_d = '0;
        if (go_fwd) begin
            fwd_d.wr   = req_write;
            fwd_d.dw   = req_dword;
            fwd_d.be   = req_be;
            fwd_d.data = req_wdata;
        end
    end

    always_comb begin
        rsp_d = '0;
        if (go_none) begin
            rsp_d = NOT_FOUND_DATA;
        end else if (go_hdr && !req_write) begin
            rsp_d = hdr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_found <= 1'b0;
            rsp_rdata <= '0;
            fwd_valid <= 1'b0;
            fwd_dev   <= '0;
            fwd_func  <= '0;
            fwd_q     <= '0;
        end else begin
            rsp_valid <= go_hdr || go_none;
            rsp_found <= go_hdr;
            rsp_rdata <= rsp_d;
            fwd_valid <= go_fwd;
            fwd_dev   <= go_fwd ? FWD_DEV : 5'd0;
            fwd_func  <= go_fwd ? FWD_FUNC : 3'd0;
            fwd_q     <= fwd_d;
        end
    end

    assign fwd_type  = 1'b0;
    assign fwd_write = fwd_q.wr;
    assign fwd_dword = fwd_q.dw;
    assign fwd_be    = fwd_q.be;
    assign fwd_wdata = fwd_q.data;

endmodule

// File: rtl/cb_hdr_emu.sv
module cb_hdr_emu
    import cbh_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID   = 16'h6348,
    parameter logic [4:0]  BRIDGE_SLOT = 5'h1E,
    parameter logic [4:0]  FWD_DEV     = 5'd8,
    parameter logic [2:0]  FWD_FUNC    = 3'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_root,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_slot,
    input  logic [5:0]  req_dword,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_found,
    output logic [31:0] rsp_rdata,
    output logic        fwd_valid,
    output logic        fwd_write,
    output logic        fwd_type,
    output logic [4:0]  fwd_dev,
    output logic [2:0]  fwd_func,
    output logic [5:0]  fwd_dword,
    output logic [3:0]  fwd_be,
    output logic [31:0] fwd_wdata
);

    route_e            route;
    logic              bus_assigned;
    logic [7:0]        cb_bus;
    logic [DATA_W-1:0] hdr_rdata;
    logic              hdr_wr;

    assign hdr_wr = req_valid && req_write && (route == RT_HDR);

    cbh_router #(
        .BRIDGE_SLOT (BRIDGE_SLOT)
    ) u_router (
        .req_root     (req_root),
        .req_bus      (req_bus),
        .req_slot     (req_slot),
        .bus_assigned (bus_assigned),
        .cb_bus       (cb_bus),
        .route        (route)
    );

    cbh_hdr_regs #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (hdr_wr),
        .dw           (req_dword),
        .be           (req_be),
        .wdata        (req_wdata),
        .rd_data      (hdr_rdata),
        .bus_assigned (bus_assigned),
        .cb_bus       (cb_bus)
    );

    cbh_outreg #(
        .FWD_DEV  (FWD_DEV),
        .FWD_FUNC (FWD_FUNC)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .route     (route),
        .req_write (req_write),
        .req_dword (req_dword),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .hdr_rdata (hdr_rdata),
        .rsp_valid (rsp_valid),
        .rsp_found (rsp_found),
        .rsp_rdata (rsp_rdata),
        .fwd_valid (fwd_valid),
        .fwd_write (fwd_write),
        .fwd_type  (fwd_type),
        .fwd_dev   (fwd_dev),
        .fwd_func  (fwd_func),
        .fwd_dword (fwd_dword),
        .fwd_be    (fwd_be),
        .fwd_wdata (fwd_wdata)
    );

endmodule

// File: rtl/cbh_checker.sv
module cbh_checker #(
    parameter logic [4:0] FWD_DEV  = 5'd8,
    parameter logic [2:0] FWD_FUNC = 3'd0
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [4:0]  req_slot,
    input logic        rsp_valid,
    input logic        rsp_found,
    input logic [31:0] rsp_rdata,
    input logic        fwd_valid,
    input logic        fwd_type,
    input logic [4:0]  fwd_dev,
    input logic [2:0]  fwd_func
);

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && fwd_valid)); // R1

    AST_ONE_CYCLE_REPLY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_valid || fwd_valid)); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !fwd_valid)); // R1

    AST_NOT_FOUND_ONES: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_found) |-> (rsp_rdata == 32'hFFFF_FFFF)); // R10

    AST_FWD_TARGET: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_type == 1'b0 && fwd_dev == FWD_DEV && fwd_func == FWD_FUNC)); // R9

    AST_FWD_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_slot != 5'd0) |=> !fwd_valid); // R9

endmodule

bind cb_hdr_emu cbh_checker #(
    .FWD_DEV  (FWD_DEV),
    .FWD_FUNC (FWD_FUNC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_slot  (req_slot),
    .rsp_valid (rsp_valid),
    .rsp_found (rsp_found),
    .rsp_rdata (rsp_rdata),
    .fwd_valid (fwd_valid),
    .fwd_type  (fwd_type),
    .fwd_dev   (fwd_dev),
    .fwd_func  (fwd_func)
);

// File: tb/tb_cb_hdr_emu.sv
module tb_cb_hdr_emu;

    localparam logic [15:0] VID = 16'h1A2B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_root = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_slot = '0;
    logic [5:0]  req_dword = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_found, fwd_valid, fwd_write, fwd_type;
    logic [31:0] rsp_rdata, fwd_wdata;
    logic [4:0]  fwd_dev;
    logic [2:0]  fwd_func;
    logic [5:0]  fwd_dword;
    logic [3:0]  fwd_be;

    always #5 clk = ~clk;

    cb_hdr_emu #(.VENDOR_ID(VID)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_root(req_root), .req_bus(req_bus), .req_slot(req_slot),
        .req_dword(req_dword), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_rdata(rsp_rdata),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_type(fwd_type),
        .fwd_dev(fwd_dev), .fwd_func(fwd_func), .fwd_dword(fwd_dword),
        .fwd_be(fwd_be), .fwd_wdata(fwd_wdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_cmd, m_bctl;
    logic [31:0] m_bus;
    logic [31:0] m_win [8];
    bit          m_asg;

    // expected outputs for the next sample
    logic        e_rv, e_rf, e_fv, e_fw;
    logic [31:0] e_rd, e_fd;
    logic [4:0]  e_dev;
    logic [5:0]  e_fdw;
    logic [3:0]  e_fbe;
    string       e_tag;

    function automatic logic [31:0] m_read(int dw);
        if (dw == 0 || dw == 16) return {16'h6348, VID};
        if (dw == 1)  return {16'h0400, m_cmd};
        if (dw == 2)  return 32'h0607_0000;
        if (dw == 3)  return 32'h0002_0000;
        if (dw == 6)  return m_bus;
        if (dw == 15) return {m_bctl, 16'h01FF};
        if (dw >= 7 && dw <= 14) return m_win[dw-7] | ((dw == 11 || dw == 13) ? 32'd1 : 32'd0);
        return 32'h0;
    endfunction

    task automatic m_reset();
        m_cmd = '0; m_bctl = '0; m_bus = '0; m_asg = 0;
        for (int i = 0; i < 8; i++) m_win[i] = '0;
    endtask

    task automatic clear_exp(string tag);
        e_rv = 0; e_rf = 0; e_rd = 0; e_fv = 0; e_fw = 0;
        e_fd = 0; e_dev = 0; e_fdw = 0; e_fbe = 0; e_tag = tag;
    endtask

    task automatic compare();
        checks++;
        if ({rsp_valid, rsp_found, rsp_rdata, fwd_valid, fwd_write, fwd_type,
             fwd_dev, fwd_func, fwd_dword, fwd_be, fwd_wdata} !==
            {e_rv, e_rf, e_rd, e_fv, e_fw, 1'b0, e_dev, 3'd0, e_fdw, e_fbe, e_fd}) begin
            errors++;
            $display("FAIL %s: actual rsp v%0b f%0b d=%h fwd v%0b w%0b t%0b dev%0d fn%0d dw%0d be%h d=%h | expected rsp v%0b f%0b d=%h fwd v%0b w%0b t0 dev%0d fn0 dw%0d be%h d=%h",
                     e_tag, rsp_valid, rsp_found, rsp_rdata, fwd_valid, fwd_write, fwd_type,
                     fwd_dev, fwd_func, fwd_dword, fwd_be, fwd_wdata,
                     e_rv, e_rf, e_rd, e_fv, e_fw, e_dev, e_fdw, e_fbe, e_fd);
        end
    endtask

    task automatic step(bit v, bit wr, bit root, logic [7:0] bus, logic [4:0] slot,
                        logic [5:0] dw, logic [3:0] be, logic [31:0] wd, string tag);
        logic [31:0] cur, m, mg;
        @(negedge clk);
        compare();
        req_valid = v; req_write = wr; req_root = root; req_bus = bus;
        req_slot = slot; req_dword = dw; req_be = be; req_wdata = wd;
        clear_exp(tag);
        if (v) begin
            if (root && slot == 5'h1E) begin
                e_rv = 1; e_rf = 1;
                cur = m_read(int'(dw));
                if (!wr) begin
                    e_rd = cur;
                end else begin
                    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
                    mg = (cur & ~m) | (wd & m);
                    if (dw == 1) m_cmd = mg[15:0];
                    if (dw == 6) begin
                        m_bus = mg;
                        if (mg[15:8] != 0) m_asg = 1;
                    end
                    if (dw == 15) m_bctl = mg[31:16] & 16'hFCFF;
                    if (dw >= 7 && dw <= 14) m_win[dw-7] = mg;
                end
            end else if (m_asg && bus == m_bus[15:8] && slot == 0) begin
                e_fv = 1; e_fw = wr; e_dev = 5'd8; e_fdw = dw; e_fbe = be; e_fd = wd;
            end else begin
                e_rv = 1; e_rd = 32'hFFFF_FFFF;
            end
        end
    endtask

    task automatic rd(bit root, logic [7:0] bus, logic [4:0] slot, logic [5:0] dw, string tag);
        step(1, 0, root, bus, slot, dw, 4'hF, 32'h0, tag);
    endtask

    task automatic wr(bit root, logic [7:0] bus, logic [4:0] slot, logic [5:0] dw,
                      logic [3:0] be, logic [31:0] wd, string tag);
        step(1, 1, root, bus, slot, dw, be, wd, tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 8'h0, 5'h0, 6'h0, 4'h0, 32'h0, tag);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        compare();
        rst = 1; req_valid = 0;
        m_reset();
        clear_exp("R12 reset state");
        @(negedge clk);
        compare();
        rst = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        clear_exp("R12 reset state");
        repeat (2) @(negedge clk);
        rst = 0;
        idle("R12 reset state");
        idle("R12 reset state");
        rd(1, 8'h00, 5'h1E, 6'd1, "R12 command zero after reset");
        rd(1, 8'h00, 5'h1E, 6'd6, "R12 bus zero after reset");
        // identity constants
        rd(1, 8'h00, 5'h1E, 6'd0, "R2 ident");
        rd(1, 8'h00, 5'h1E, 6'd16, "R2 subsystem ident");
        rd(1, 8'h00, 5'h1E, 6'd2, "R2 class");
        rd(1, 8'h00, 5'h1E, 6'd3, "R2 header type");
        // routing: root/slot qualifiers
        rd(1, 8'h00, 5'h1D, 6'd0, "R10 other root slot");
        rd(0, 8'h00, 5'h1E, 6'd0, "R1 bridge slot off root");
        wr(0, 8'h03, 5'h05, 6'd1, 4'hF, 32'hFFFF_FFFF, "R10 not-found write");
        rd(1, 8'h00, 5'h1E, 6'd1, "R10 header untouched");
        idle("R1 idle");
        // command
        wr(1, 8'h00, 5'h1E, 6'd1, 4'hF, 32'hFFFF_1234, "R11 write completion");
        rd(1, 8'h00, 5'h1E, 6'd1, "R3 command low half");
        wr(1, 8'h00, 5'h1E, 6'd1, 4'b0010, 32'h0000_5600, "R8 command lane 1");
        rd(1, 8'h00, 5'h1E, 6'd1, "R8 command merged");
        // bus numbers, unassigned
        wr(1, 8'h00, 5'h1E, 6'd6, 4'hF, 32'h4003_0001, "R4 bus write");
        rd(1, 8'h00, 5'h1E, 6'd6, "R4 bus packing");
        rd(0, 8'h00, 5'h00, 6'd0, "R5 unassigned no forward");
        wr(1, 8'h00, 5'h1E, 6'd6, 4'b0010, 32'h0000_0500, "R8 bus lane 1");
        rd(1, 8'h00, 5'h1E, 6'd6, "R8 bus merged");
        // forwarding
        rd(0, 8'h05, 5'h00, 6'd3, "R9 forward read");
        wr(0, 8'h05, 5'h00, 6'd4, 4'b0101, 32'hDEAD_BEEF, "R9 forward write");
        rd(0, 8'h05, 5'h01, 6'd0, "R9 other slot not found");
        rd(0, 8'h06, 5'h00, 6'd0, "R9 other bus not found");
        idle("R1 idle");
        // sticky flag
        wr(1, 8'h00, 5'h1E, 6'd6, 4'b0010, 32'h0, "R5 clear cb bus");
        rd(0, 8'h00, 5'h00, 6'd2, "R5 flag sticky forward");
        rd(0, 8'h05, 5'h00, 6'd2, "R5 old bus not found");
        // bridge control
        wr(1, 8'h00, 5'h1E, 6'd15, 4'hF, 32'hFFFF_0000, "R6 bctl write");
        rd(1, 8'h00, 5'h1E, 6'd15, "R6 prefetch cleared");
        wr(1, 8'h00, 5'h1E, 6'd15, 4'b0001, 32'h0000_0012, "R6 irq line write");
        rd(1, 8'h00, 5'h1E, 6'd15, "R6 pin and line fixed");
        wr(1, 8'h00, 5'h1E, 6'd15, 4'b0100, 32'h0003_0000, "R6 low bctl lane");
        rd(1, 8'h00, 5'h1E, 6'd15, "R8 bctl merged");
        // windows
        for (int i = 7; i <= 14; i++) begin
            wr(1, 8'h00, 5'h1E, 6'(i), 4'hF, 32'h1000_0000 + 32'(i) * 32'h0011_1100, "R7 window write");
            rd(1, 8'h00, 5'h1E, 6'(i), "R7 window read");
        end
        wr(1, 8'h00, 5'h1E, 6'd11, 4'hF, 32'h0000_1000, "R7 io base0 even");
        rd(1, 8'h00, 5'h1E, 6'd11, "R7 io base0 bit0");
        wr(1, 8'h00, 5'h1E, 6'd13, 4'hF, 32'h0000_2000, "R7 io base1 even");
        rd(1, 8'h00, 5'h1E, 6'd13, "R7 io base1 bit0");
        wr(1, 8'h00, 5'h1E, 6'd12, 4'hF, 32'h0000_3000, "R7 io limit0");
        rd(1, 8'h00, 5'h1E, 6'd12, "R7 io limit no force");
        wr(1, 8'h00, 5'h1E, 6'd7, 4'b1000, 32'hAB00_0000, "R8 window lane 3");
        rd(1, 8'h00, 5'h1E, 6'd7, "R8 window merged");
        // unimplemented
        wr(1, 8'h00, 5'h1E, 6'd4, 4'hF, 32'h1234_5678, "R11 write dword 4");
        rd(1, 8'h00, 5'h1E, 6'd4, "R11 dword 4 zero");
        wr(1, 8'h00, 5'h1E, 6'd63, 4'hF, 32'hFFFF_FFFF, "R11 write dword 63");
        rd(1, 8'h00, 5'h1E, 6'd63, "R11 dword 63 zero");
        rd(1, 8'h00, 5'h1E, 6'd5, "R11 dword 5 zero");
        // back-to-back mix
        rd(0, 8'h00, 5'h00, 6'd9, "R9 back-to-back forward");
        rd(1, 8'h00, 5'h1E, 6'd0, "R1 back-to-back header");
        rd(0, 8'h00, 5'h00, 6'd9, "R9 back-to-back forward again");
        // reset clears state
        apply_reset();
        idle("R12 after reset");
        rd(1, 8'h00, 5'h1E, 6'd15, "R12 bctl cleared");
        rd(1, 8'h00, 5'h1E, 6'd7, "R12 window cleared");
        rd(0, 8'h00, 5'h00, 6'd0, "R12 flag cleared");
        idle("R1 idle");
        idle("R1 idle");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule